// File: doc/BRIEF.md
# Grouped interrupt combiner

This block folds a large set of level-sensitive interrupt sources into a small number of request lines for a parent interrupt controller. Sources are arranged in groups of eight. Each group has its own enable register byte, its own masked status byte, one request output that is high while any enabled source of the group is high, and a three-bit index naming the lowest-numbered pending source of that group.

Software reaches the block through single-cycle register access: an address, write data, a write strobe and combinational read data. Four groups share one 32-bit register bank, one byte lane each. Enables are never written directly. A write-one-to-set register turns enables on and a write-one-to-clear register turns them off, so two agents can change different sources without a read-modify-write race. The status register shows the live source levels filtered by the enables. A handler reads it, or reads the index output, to find the source to service.

Top module: `intr_combiner`

## Requirements
- R1: While reset is low, and after it is released, every enable bit is 0. Enable reads return 0 and every group request is low, whatever the source levels.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1 and leaves the bits written as 0 as they were. The new value shows from the next clock edge.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1 and leaves the bits written as 0 as they were. The new value shows from the next clock edge.
- R4: Group g sits in bank g/4 at byte address 0x10*(g/4), in register bits [8*(g%4)+7 : 8*(g%4)]. Source i of group g is input bit irq_src[8*g+i].
- R5: A read of bank offset 0xC returns, bit for bit, the current source level ANDed with its enable bit.
- R6: grp_req[g] is high exactly when at least one bit of group g's status byte is 1. It follows source changes in the same cycle.
- R7: grp_idx[3*g+2 : 3*g] gives the lowest-numbered pending source of group g, where source 0 has the highest priority. It is 0 when nothing in the group is pending.
- R8: Reads of offsets 0x0 and 0x4 both return the bank's current enable bits.
- R9: Writes to offset 0xC, to offset 0x8, to any address with bits [1:0] not zero, or to any bank beyond the last one change no enable bit. Reads of offset 0x8, of such addresses and of such banks return 0.
- R10: When NUM_GROUPS is not a multiple of four, the unused byte lanes of the last bank read 0 at every offset and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_src | input | 8*NUM_GROUPS | Level-sensitive interrupt sources, source i of group g at bit 8*g+i |
| grp_req | output | NUM_GROUPS | Combined request line for each group |
| grp_idx | output | 3*NUM_GROUPS | Lowest pending source index for each group |

## Verification
The bench builds two copies of the block. The first uses the default of 20 groups, which fills five banks completely. With it the bench can reach the highest byte lane of an inner bank, see a write to the address just past the fifth bank ignored, and follow the priority index as sources rise and fall. The second copy has 6 groups. Its second bank is then only half populated, which exposes the unused byte lanes and lets the bench show that they read zero and cannot be enabled.

// File: rtl/intr_combiner_pkg.sv
package intr_combiner_pkg;

  localparam int GRP_W        = 8;
  localparam int IDX_W        = 3;
  localparam int BANK_BITS    = 32;
  localparam int GRP_PER_BANK = BANK_BITS / GRP_W;

  typedef enum logic [1:0] {
    RK_SET  = 2'd0,
    RK_CLR  = 2'd1,
    RK_RSVD = 2'd2,
    RK_STAT = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/intr_combiner_rst_sync.sv
module intr_combiner_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/intr_combiner_decode.sv
module intr_combiner_decode
  import intr_combiner_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_BANKS  = 5,
  parameter int BANK_SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  output logic [BANK_SEL_W-1:0] bank_sel,
  output logic                  hit,
  output reg_kind_e             kind,
  output logic                  wr_set,
  output logic                  wr_clr
);

  logic [ADDR_W-5:0] bank_full;
  logic              aligned;
  logic              in_range;

  always_comb begin
    bank_full = reg_addr[ADDR_W-1:4];
    aligned   = (reg_addr[1:0] == 2'b00);
    in_range  = (int'(bank_full) < NUM_BANKS);
    hit       = aligned && in_range;
    bank_sel  = BANK_SEL_W'(bank_full);
    kind      = reg_kind_e'(reg_addr[3:2]);
    wr_set    = reg_wr && hit && (kind == RK_SET);
    wr_clr    = reg_wr && hit && (kind == RK_CLR);
  end

  // R9: at most one enable-changing strobe per access, never without a hit
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set || wr_clr) |-> ($onehot0({wr_set, wr_clr}) && hit && reg_wr));

endmodule

// File: rtl/intr_combiner_group.sv
module intr_combiner_group
  import intr_combiner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [GRP_W-1:0] wr_bits,
  input  logic [GRP_W-1:0] raw,
  output logic [GRP_W-1:0] en_o,
  output logic [GRP_W-1:0] stat_o,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [GRP_W-1:0] en_q;
  logic [GRP_W-1:0] en_d;
  logic             en_ce;

  // next-state for the enable byte
  always_comb begin
    en_ce = set_stb || clr_stb;
    en_d  = en_q;
    if (set_stb) begin
      en_d = en_q | wr_bits;
    end else if (clr_stb) begin
      en_d = en_q & ~wr_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  // masked status, request and priority pick (bit 0 wins)
  always_comb begin
    stat_o = raw & en_q;
    req_o  = |stat_o;
    idx_o  = '0;
    for (int i = GRP_W - 1; i >= 0; i--) begin
      if (stat_o[i]) begin
        idx_o = IDX_W'(i);
      end
    end
  end

  assign en_o = en_q;

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en_q & $past(wr_bits)) == $past(wr_bits)));

  assert_set_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en_q & ~$past(wr_bits)) == ($past(en_q) & ~$past(wr_bits))));

  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en_q & $past(wr_bits)) == '0));

  assert_clr_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en_q & ~$past(wr_bits)) == ($past(en_q) & ~$past(wr_bits))));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_stb || clr_stb) |=> $stable(en_q));

  assert_idx_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (stat_o[idx_o] &&
               ((stat_o & ((GRP_W'(1) << idx_o) - GRP_W'(1))) == '0)));

  assert_idx_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (idx_o == '0));

  assert_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |-> !req_o);

endmodule

// File: rtl/intr_combiner_rdmux.sv
module intr_combiner_rdmux
  import intr_combiner_pkg::*;
#(
  parameter int NUM_BANKS  = 5,
  parameter int BANK_SEL_W = 3
) (
  input  logic [NUM_BANKS*BANK_BITS-1:0] en_flat,
  input  logic [NUM_BANKS*BANK_BITS-1:0] st_flat,
  input  logic [BANK_SEL_W-1:0]          bank_sel,
  input  logic                           hit,
  input  reg_kind_e                      kind,
  output logic [BANK_BITS-1:0]           rdata
);

  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (kind)
        RK_SET, RK_CLR: rdata = en_flat[int'(bank_sel)*BANK_BITS +: BANK_BITS];
        RK_STAT:        rdata = st_flat[int'(bank_sel)*BANK_BITS +: BANK_BITS];
        default:        rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/intr_combiner.sv
module intr_combiner
  import intr_combiner_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_wr,
  input  logic [BANK_BITS-1:0]        reg_wdata,
  output logic [BANK_BITS-1:0]        reg_rdata,
  input  logic [NUM_GROUPS*GRP_W-1:0] irq_src,
  output logic [NUM_GROUPS-1:0]       grp_req,
  output logic [NUM_GROUPS*IDX_W-1:0] grp_idx
);

  localparam int NUM_BANKS  = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK;
  localparam int NUM_SLOTS  = NUM_BANKS * GRP_PER_BANK;
  localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic                           rst_n_int;
  logic [BANK_SEL_W-1:0]          bank_sel;
  logic                           hit;
  reg_kind_e                      kind;
  logic                           wr_set;
  logic                           wr_clr;
  logic [NUM_BANKS*BANK_BITS-1:0] en_flat;
  logic [NUM_BANKS*BANK_BITS-1:0] st_flat;

  intr_combiner_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  intr_combiner_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_BANKS  (NUM_BANKS),
    .BANK_SEL_W (BANK_SEL_W)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .bank_sel (bank_sel),
    .hit      (hit),
    .kind     (kind),
    .wr_set   (wr_set),
    .wr_clr   (wr_clr)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int LANE = (s % GRP_PER_BANK) * GRP_W;
    localparam int BASE = (s / GRP_PER_BANK) * BANK_BITS + LANE;
    if (s < NUM_GROUPS) begin : g_used
      logic bank_match;
      assign bank_match = (bank_sel == BANK_SEL_W'(s / GRP_PER_BANK));

      intr_combiner_group u_group (
        .clk     (clk),
        .rst_n   (rst_n_int),
        .set_stb (wr_set && bank_match),
        .clr_stb (wr_clr && bank_match),
        .wr_bits (reg_wdata[LANE +: GRP_W]),
        .raw     (irq_src[s*GRP_W +: GRP_W]),
        .en_o    (en_flat[BASE +: GRP_W]),
        .stat_o  (st_flat[BASE +: GRP_W]),
        .req_o   (grp_req[s]),
        .idx_o   (grp_idx[s*IDX_W +: IDX_W])
      );
    end else begin : g_pad
      // R10: lanes without a group read as zero
      assign en_flat[BASE +: GRP_W] = '0;
      assign st_flat[BASE +: GRP_W] = '0;
    end
  end

  intr_combiner_rdmux #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_SEL_W (BANK_SEL_W)
  ) u_rdmux (
    .en_flat  (en_flat),
    .st_flat  (st_flat),
    .bank_sel (bank_sel),
    .hit      (hit),
    .kind     (kind),
    .rdata    (reg_rdata)
  );

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_wr && !wr_set && !wr_clr) |=> $stable(en_flat));

  assert_miss_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!hit || kind == RK_RSVD) |-> (reg_rdata == '0));

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n_int |-> (en_flat == '0 && grp_req == '0));

endmodule

// File: tb/intr_combiner_bench.sv
module intr_combiner_bench;

  localparam int NG  = 20;
  localparam int NGS = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      addr = '0;
  logic            wr = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NG*8-1:0] src = '0;
  logic [NG-1:0]   req;
  logic [NG*3-1:0] idx;

  logic [7:0]       s_addr = '0;
  logic             s_wr = 1'b0;
  logic [31:0]      s_wdata = '0;
  logic [31:0]      s_rdata;
  logic [NGS*8-1:0] s_src = '0;
  logic [NGS-1:0]   s_req;
  logic [NGS*3-1:0] s_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  intr_combiner #(.NUM_GROUPS(NG), .ADDR_W(8)) u_intr_combiner (
    .clk (clk), .rst_n (rst_n), .reg_addr (addr), .reg_wr (wr),
    .reg_wdata (wdata), .reg_rdata (rdata), .irq_src (src),
    .grp_req (req), .grp_idx (idx)
  );

  intr_combiner #(.NUM_GROUPS(NGS), .ADDR_W(8)) u_intr_combiner_small (
    .clk (clk), .rst_n (rst_n), .reg_addr (s_addr), .reg_wr (s_wr),
    .reg_wdata (s_wdata), .reg_rdata (s_rdata), .irq_src (s_src),
    .grp_req (s_req), .grp_idx (s_idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic s_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    s_addr = a; s_wdata = d; s_wr = 1'b1;
    @(negedge clk);
    s_wr = 1'b0;
  endtask

  task automatic s_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    s_addr = a;
    #1 d = s_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    src = '1;
    for (int b = 0; b < 5; b++) begin
      reg_read(8'(b*16), d);
      chk("R1 enable after reset", d, 32'h0);
    end
    #1 chk("R1 no request after reset", 32'(req), 32'h0);
    src = '0;
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    reg_write(8'h00, 32'h0000_00A5);
    reg_read(8'h00, d);
    chk("R2 set bits", d, 32'h0000_00A5);
    reg_write(8'h00, 32'h0000_0102);
    reg_read(8'h00, d);
    chk("R2 zero bits keep", d, 32'h0000_01A7);
    reg_write(8'h04, 32'h0000_0005);
    reg_read(8'h00, d);
    chk("R3 clear bits", d, 32'h0000_01A2);
    reg_read(8'h04, d);
    chk("R8 read via clear offset", d, 32'h0000_01A2);
  endtask

  task automatic t_status();
    logic [31:0] d;
    src[7:0] = 8'hFF;
    reg_read(8'h0C, d);
    chk("R5 status masked", d, 32'h0000_00A2);
    chk("R7 idx group0", 32'(idx[2:0]), 32'd1);
    chk("R6 req group0", 32'(req[0]), 32'd1);
    src[7:0] = 8'h5D;
    reg_read(8'h0C, d);
    chk("R5 status no overlap", d, 32'h0000_0000);
    chk("R6 req group0 idle", 32'(req[0]), 32'd0);
    src[7:0] = 8'h00;
  endtask

  task automatic t_map();
    logic [31:0] d;
    reg_write(8'h30, 32'hFF00_0000);
    src[15*8+2] = 1'b1;
    reg_read(8'h3C, d);
    chk("R4 group15 status lane", d, 32'h0400_0000);
    chk("R4 group15 req only", 32'(req), 32'(1 << 15));
    chk("R7 group15 idx", 32'(idx[45 +: 3]), 32'd2);
    reg_read(8'h20, d);
    chk("R4 other bank untouched", d, 32'h0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    src[15*8+5] = 1'b1;
    src[15*8+7] = 1'b1;
    #1 chk("R7 lowest wins", 32'(idx[45 +: 3]), 32'd2);
    @(negedge clk);
    src[15*8+2] = 1'b0;
    #1 chk("R7 next lowest", 32'(idx[45 +: 3]), 32'd5);
    reg_write(8'h34, 32'h2000_0000);
    #1 chk("R3 R7 cleared bit skipped", 32'(idx[45 +: 3]), 32'd7);
    reg_read(8'h30, d);
    chk("R3 lane enables", d, 32'hDF00_0000);
    src[15*8+7] = 1'b0;
    #1 chk("R6 none pending", 32'(req[15]), 32'd0);
    chk("R7 idle idx", 32'(idx[45 +: 3]), 32'd0);
    src = '0;
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    reg_write(8'h0C, 32'hFFFF_FFFF);
    reg_write(8'h08, 32'hFFFF_FFFF);
    reg_write(8'h01, 32'hFFFF_FFFF);
    reg_write(8'h50, 32'hFFFF_FFFF);
    reg_write(8'h54, 32'hFFFF_FFFF);
    reg_read(8'h00, d);
    chk("R9 enables unchanged bank0", d, 32'h0000_01A2);
    reg_read(8'h30, d);
    chk("R9 enables unchanged bank3", d, 32'hDF00_0000);
    reg_read(8'h08, d);
    chk("R9 reserved reads zero", d, 32'h0);
    reg_read(8'h01, d);
    chk("R9 misaligned reads zero", d, 32'h0);
    reg_read(8'h50, d);
    chk("R9 past last bank reads zero", d, 32'h0);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    s_write(8'h10, 32'hFFFF_FFFF);
    s_read(8'h10, d);
    chk("R10 unused lanes read zero", d, 32'h0000_FFFF);
    s_src = '1;
    s_read(8'h1C, d);
    chk("R10 status of unused lanes", d, 32'h0000_FFFF);
    chk("R10 small requests", 32'(s_req), 32'h30);
    s_read(8'h20, d);
    chk("R9 small past last bank", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 request during reset", 32'(req), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_clear();
    t_status();
    t_map();
    t_prio();
    t_ignore();
    t_partial();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule